// File: doc/BRIEF.md
# Bit and Error Counter with Triggered Snapshot

This block sits on the receive side of a bit-error-rate tester. Each clock that carries a valid received bit adds one to a running bit count. If that bit is also marked as errored, it adds one to a running error count. On an update trigger, both running counts are copied into holding registers and both counters restart from zero. Software then reads a stable pair of values for the interval that has just ended, while the next interval is already being counted.

The update trigger has two possible sources. One is a control bit that software writes. The other is an external update input shared across ports or across the chip. A source-select bit chooses between them. Only a rising edge of the selected trigger starts an update. Edge detection runs on the selected level itself, so changing the select bit while the two sources differ can produce an update.

A 16-bit word-addressed register port exposes the control bits, a live update-done flag, a latched copy of that flag with its interrupt enable, and the two snapshot counts. Each count is read as a low half and a high half, and both halves come from the same snapshot.

Top module: `bert_snapshot_counter`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: In each clock where `bit_vld` is 1, the running bit count rises by one. The running error count rises by one only when `bit_vld` and `bit_err` are both 1. `bit_err` has no effect while `bit_vld` is 0.
- R3: A 0-to-1 change of the selected trigger copies both running counts into the snapshot registers and restarts both counters. The external input takes effect at the first clock edge where it is seen high after being low. A write that sets the local bit takes effect at the clock edge after the write edge.
- R4: Holding the selected trigger at 1 gives no further update. A new update needs the trigger to return to 0 and then rise again.
- R5: CTRL (offset 0x60) bit 0 is the local trigger and bit 1 is the source select: 0 selects the local bit, 1 selects `ext_upd`. The source that is not selected has no effect.
- R6: An update also occurs when a write to the select bit switches from a source at 0 to a source at 1. Switching from 1 to 0 causes no update.
- R7: Byte offsets are 0x74 (error count bits 15:0), 0x76 (error count bits 31:16), 0x78 (bit count bits 15:0) and 0x7A (bit count bits 31:16). Unmapped offsets read 0.
- R8: A valid bit in the same clock as an update is counted into the new interval, not into the snapshot.
- R9: Each running counter stops at 2^CNT_W-1 and does not wrap.
- R10: STAT (0x68) bit 0 becomes 1 at the update edge. It returns to 0 at the first edge where the selected trigger is 0.
- R11: LSTAT (0x6A) bit 0 is set by every update and cleared by writing 1 to it; a set in the same cycle as a clear wins. IEN (0x6C) keeps all 16 written bits. `irq` is LSTAT bit 0 AND IEN bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | A received bit is present this cycle |
| bit_err | input | 1 | The present bit is in error |
| ext_upd | input | 1 | External global/port update level |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request for a latched update |

## Verification
Counting and a snapshot can fall in the same clock. At that edge the counter must restart, and the bit present in that clock must go into the fresh interval. To provoke this, the bench holds `bit_vld` high over several edges and raises `ext_upd` so that its first high edge is also a counting edge. It then expects the snapshot to hold only the bits counted before that edge. A second update must then show exactly one bit for the clock that coincided with the first update.

// File: rtl/bsnap_pkg.sv
package bsnap_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int VIS_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_LSTAT  = 8'h6A;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h6C;
    localparam logic [ADDR_W-1:0] OFS_ERR_LO = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_ERR_HI = 8'h76;
    localparam logic [ADDR_W-1:0] OFS_BIT_LO = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_BIT_HI = 8'h7A;

    typedef struct packed {
        logic src_ext;
        logic loc_upd;
    } ctrl_t;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_STEP,
        CNT_RESTART
    } cnt_op_e;

    function automatic logic [DATA_W-1:0] half_of(input logic [VIS_W-1:0] v, input logic hi);
        return hi ? v[VIS_W-1:DATA_W] : v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/bsnap_trig.sv
module bsnap_trig
    import bsnap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  ext_upd,
    output logic  upd,
    output logic  done
);
    logic trig_sel;
    logic trig_q;

    assign trig_sel = ctrl.src_ext ? ext_upd : ctrl.loc_upd;
    assign upd      = trig_sel & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            trig_q <= trig_sel;
            if (!trig_sel)
                done <= 1'b0;
            else if (upd)
                done <= 1'b1;
        end
    end

    // R10
    upd_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> done);

    // R4
    held_no_retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (done && trig_sel) |-> !upd);

endmodule

// File: rtl/bsnap_counter.sv
module bsnap_counter
    import bsnap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             upd,
    output logic [CNT_W-1:0] snap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run;
    cnt_op_e          op;

    always_comb begin
        if (upd)
            op = CNT_RESTART;
        else if (inc && run != CNT_MAX)
            op = CNT_STEP;
        else
            op = CNT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            snap <= '0;
        end else begin
            case (op)
                CNT_RESTART: begin
                    snap <= run;
                    run  <= inc ? CNT_W'(1) : '0;
                end
                CNT_STEP: run <= run + CNT_W'(1);
                default:  run <= run;
            endcase
        end
    end

    // R3
    snap_only_on_upd_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(snap));

    // R8
    restart_value_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (run == CNT_W'($past(inc))));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run == CNT_MAX && !upd) |=> run == CNT_MAX);

endmodule

// File: rtl/bsnap_regs.sv
module bsnap_regs
    import bsnap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              upd,
    input  logic              done,
    input  logic [VIS_W-1:0]  err_vis,
    input  logic [VIS_W-1:0]  bit_vis,
    output ctrl_t             ctrl,
    output logic              irq
);
    logic [DATA_W-1:0] ien;
    logic              lat;
    logic              wr_ctrl, wr_lstat, wr_ien;

    assign wr_ctrl  = reg_wr && reg_addr == OFS_CTRL;
    assign wr_lstat = reg_wr && reg_addr == OFS_LSTAT;
    assign wr_ien   = reg_wr && reg_addr == OFS_IEN;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ien  <= '0;
            lat  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= reg_wdata[1:0];
            if (wr_ien)
                ien <= reg_wdata;
            if (upd)
                lat <= 1'b1;
            else if (wr_lstat && reg_wdata[0])
                lat <= 1'b0;
        end
    end

    assign irq = lat & ien[0];

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:   reg_rdata[1:0] = ctrl;
            OFS_STAT:   reg_rdata[0]   = done;
            OFS_LSTAT:  reg_rdata[0]   = lat;
            OFS_IEN:    reg_rdata      = ien;
            OFS_ERR_LO: reg_rdata      = half_of(err_vis, 1'b0);
            OFS_ERR_HI: reg_rdata      = half_of(err_vis, 1'b1);
            OFS_BIT_LO: reg_rdata      = half_of(bit_vis, 1'b0);
            OFS_BIT_HI: reg_rdata      = half_of(bit_vis, 1'b1);
            default:    reg_rdata      = '0;
        endcase
    end

    // R11
    lat_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> lat);

    // R11
    lat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lstat && reg_wdata[0] && !upd) |=> !lat);

endmodule

// File: rtl/bert_snapshot_counter.sv
module bert_snapshot_counter
    import bsnap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_err,
    input  logic              ext_upd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NCNT = 2;

    ctrl_t              ctrl;
    logic               upd;
    logic               done;
    logic [NCNT-1:0]    inc;
    logic [CNT_W-1:0]   snap [NCNT];
    logic [VIS_W-1:0]   vis  [NCNT];

    assign inc[0] = bit_vld;
    assign inc[1] = bit_vld & bit_err;

    bsnap_trig u_trig (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .ext_upd (ext_upd),
        .upd     (upd),
        .done    (done)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        bsnap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .inc  (inc[g]),
            .upd  (upd),
            .snap (snap[g])
        );
        always_comb begin
            vis[g] = '0;
            vis[g][CNT_W-1:0] = snap[g];
        end
    end

    bsnap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .upd       (upd),
        .done      (done),
        .err_vis   (vis[1]),
        .bit_vis   (vis[0]),
        .ctrl      (ctrl),
        .irq       (irq)
    );

    // R5
    local_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.src_ext && $past(ctrl.src_ext) && !ext_upd) |-> !upd);

    // R5
    ext_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.src_ext && !$past(ctrl.src_ext) && !ctrl.loc_upd) |-> !upd);

    // R2
    err_within_bits_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (vis[1] <= vis[0]));

endmodule

// File: tb/sim_bert_snapshot_counter.sv
module sim_bert_snapshot_counter;
    import bsnap_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0, bit_err = 1'b0, ext_upd = 1'b0;
    logic [7:0]  a0 = '0, a1 = '0;
    logic        w0 = 1'b0, w1 = 1'b0;
    logic [15:0] d0 = '0, d1 = '0;
    logic [15:0] q0, q1;
    logic        irq0, irq1;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bert_snapshot_counter u0 (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err), .ext_upd(ext_upd),
        .reg_addr(a0), .reg_wr(w0), .reg_wdata(d0), .reg_rdata(q0), .irq(irq0));

    bert_snapshot_counter #(.CNT_W(8)) u1 (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err), .ext_upd(ext_upd),
        .reg_addr(a1), .reg_wr(w1), .reg_wdata(d1), .reg_rdata(q1), .irq(irq1));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] ad, input logic [15:0] dt);
        @(negedge clk);
        if (sel) begin a1 = ad; d1 = dt; w1 = 1'b1; end
        else     begin a0 = ad; d0 = dt; w0 = 1'b1; end
        @(negedge clk);
        w0 = 1'b0; w1 = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [7:0] ad, output int v);
        if (sel) a1 = ad; else a0 = ad;
        #1;
        v = sel ? int'(q1) : int'(q0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stream(input int n, input int err_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_err = (err_every > 0) && (i % err_every == 0);
        end
        @(negedge clk);
        bit_vld = 1'b0; bit_err = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        logic [7:0] ofs [8] = '{8'h60, 8'h68, 8'h6A, 8'h6C, 8'h74, 8'h76, 8'h78, 8'h7A};
        for (int i = 0; i < 8; i++) begin
            rd(0, ofs[i], v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 irq after reset", int'(irq0), 0);
    endtask

    task automatic t_local;
        int v;
        stream(20, 7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bit_err = 1'b1;
        end
        @(negedge clk); bit_err = 1'b0;
        wr(0, 8'h60, 16'h0001);
        idle(1);
        rd(0, 8'h74, v); check("R2 error count lo", v, 3);
        rd(0, 8'h76, v); check("R7 error count hi", v, 0);
        rd(0, 8'h78, v); check("R3 bit count lo", v, 20);
        rd(0, 8'h7A, v); check("R7 bit count hi", v, 0);
        rd(0, 8'h68, v); check("R10 done live", v, 1);
        rd(0, 8'h6A, v); check("R11 latched done", v, 1);
        check("R11 irq masked", int'(irq0), 0);
        rd(0, 8'h10, v); check("R7 unmapped offset", v, 0);
    endtask

    task automatic t_hold;
        int v;
        stream(5, 0);
        idle(2);
        rd(0, 8'h78, v); check("R4 held trigger no update", v, 20);
        wr(0, 8'h60, 16'h0000);
        idle(1);
        rd(0, 8'h68, v); check("R10 done clears", v, 0);
        wr(0, 8'h60, 16'h0001);
        idle(1);
        rd(0, 8'h78, v); check("R4 re-armed update", v, 5);
        rd(0, 8'h74, v); check("R4 error count restarted", v, 0);
    endtask

    task automatic t_irq;
        int v;
        wr(0, 8'h6C, 16'hA5A1);
        rd(0, 8'h6C, v); check("R11 enable readback", v, 16'hA5A1);
        #1; check("R11 irq raised", int'(irq0), 1);
        wr(0, 8'h6A, 16'h0001);
        rd(0, 8'h6A, v); check("R11 w1c clears", v, 0);
        #1; check("R11 irq dropped", int'(irq0), 0);
    endtask

    task automatic t_ext;
        int v;
        wr(0, 8'h60, 16'h0002);
        stream(7, 0);
        wr(0, 8'h60, 16'h0003);
        idle(1);
        rd(0, 8'h78, v); check("R5 local ignored in ext mode", v, 5);
        rd(0, 8'h68, v); check("R5 no done from local", v, 0);
        @(negedge clk); ext_upd = 1'b1;
        @(negedge clk);
        rd(0, 8'h78, v); check("R3 ext edge update", v, 7);
        #1; check("R11 irq from ext update", int'(irq0), 1);
    endtask

    task automatic t_same_cycle;
        int v;
        @(negedge clk); ext_upd = 1'b0; bit_vld = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); ext_upd = 1'b1;
        @(negedge clk); bit_vld = 1'b0;
        rd(0, 8'h78, v); check("R8 snapshot excludes coinciding bit", v, 3);
        @(negedge clk); ext_upd = 1'b0;
        @(negedge clk); ext_upd = 1'b1;
        @(negedge clk);
        rd(0, 8'h78, v); check("R8 coinciding bit in new interval", v, 1);
    endtask

    task automatic t_switch;
        int v;
        @(negedge clk); ext_upd = 1'b0;
        wr(0, 8'h60, 16'h0000);
        stream(4, 0);
        @(negedge clk); ext_upd = 1'b1;
        idle(2);
        rd(0, 8'h78, v); check("R5 ext ignored in local mode", v, 1);
        wr(0, 8'h60, 16'h0002);
        idle(1);
        rd(0, 8'h78, v); check("R6 mode switch to high source", v, 4);
        stream(2, 0);
        wr(0, 8'h60, 16'h0000);
        idle(1);
        rd(0, 8'h78, v); check("R6 switch to low source no update", v, 4);
        @(negedge clk); ext_upd = 1'b0;
    endtask

    task automatic t_sat;
        int v;
        wr(1, 8'h60, 16'h0001);
        wr(1, 8'h60, 16'h0000);
        stream(300, 1);
        wr(1, 8'h60, 16'h0001);
        idle(1);
        rd(1, 8'h78, v); check("R9 bit count saturates", v, 255);
        rd(1, 8'h74, v); check("R9 error count saturates", v, 255);
        rd(1, 8'h7A, v); check("R9 hi half zero", v, 0);
    endtask

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_local();
        t_hold();
        t_irq();
        t_ext();
        t_same_cycle();
        t_switch();
        t_sat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule